// File: doc/BRIEF.md
# Shared-Bus Arbiter with Repeat Limits

This block decides which of several bus masters may start the next address phase on a single shared system bus. Master slot `CORE_IDX` is the processor core, slot `PCI_IDX` is the PCI master, and every other slot is a generic master. Each master drives a request line and a companion "hold" flag. The flag asks to keep the bus for back-to-back transactions. The arbiter answers with a one-cycle, one-hot grant pulse for each transaction it admits.

Ordinary requests are served in round-robin order. A master that wins while its hold flag is set may keep winning until it reaches its consecutive-grant limit. The PCI master has its own limit, and all other masters share a second one. The arbiter also keeps a count of transactions that have been granted but not yet completed. It stops granting while that count has reached the programmed pipeline depth. A lock bit can exclude the core from arbitration altogether. The lock bit loads from a boot strap input at reset, and software can clear it later. All settings live in one 32-bit control word that is written and read back through a simple register port.

Top module: `sbus_arbiter`

## Requirements
- R1: While `rst` is high, `gnt` is 0. After reset, `cfg_rdata` equals `{31'b0, boot_core_off}`, so the core lock bit comes from the strap input and all other fields are 0.
- R2: A write with `cfg_we` high stores the control word, and the stored value is visible on `cfg_rdata` from the next cycle. The field positions are: bit 0 is the core lock, bits [6:4] are the depth code, bits [10:8] are the PCI hold code and bits [14:12] are the shared hold code. All other bits always read 0, whatever is written to them.
- R3: While the core lock bit is 1, `gnt[CORE_IDX]` is never asserted, even when the core requests. After software clears the lock bit, a core request is granted normally.
- R4: `gnt` has at most one bit set. A bit is set only one cycle after the matching `req` bit was sampled high, and a grant appears on the cycle after its request when room is available.
- R5: Depth codes 0, 1, 2 and 3 allow 1, 2, 3 and 4 outstanding transactions. Any code with bit 2 set acts as depth 1.
- R6: The outstanding count rises with each grant pulse and falls with each `xfer_done` pulse. `xfer_done` is ignored when nothing is outstanding. A grant is issued only when the current outstanding count plus the grant now on the output is below the depth. After a `xfer_done` that frees room, the next grant appears two cycles later.
- R7: When no master is extending a burst, the winner is the first requesting master found when searching upward, with wrap-around, from the slot after the most recent winner. After reset, the search starts at slot 0.
- R8: The PCI master, while its hold flag stays high, wins consecutively at most (PCI hold code + 1) times. Hold code 0 means each PCI grant goes through round-robin.
- R9: Every master other than PCI, while its hold flag stays high, wins consecutively at most (shared hold code + 1) times. When the limit is reached, the rotation moves on. The holder wins again only if it is the sole requester, and that grant starts a fresh count.
- R10: When all masters keep requesting, each eligible master is granted within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_core_off | input | 1 | Strap value loaded into the core lock bit at reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| req | input | NUM_M | Per-master request |
| rpt_req | input | NUM_M | Per-master hold (burst extension) flag |
| xfer_done | input | 1 | Data-completion pulse for one outstanding transaction |
| gnt | output | NUM_M | One-hot grant pulse |

## Verification
A request or hold pattern sampled at one clock edge produces its grant on `gnt` at that same edge, so the result is visible one cycle later. Control word writes appear on `cfg_rdata` one cycle after the strobe. A completion pulse frees room at the edge that samples it, and the resulting grant arrives one edge after that, two cycles in total. The bench drives every input just after a falling edge and samples one full cycle later. For completions, it checks the intermediate cycle for no grant and then the following cycle for the grant. The round-robin and burst-limit vector table holds each row for exactly one cycle, so each row's expected grant reflects the state left behind by the row before it.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;

    localparam int CFG_W  = 32;
    localparam int CODE_W = 3;
    localparam int OCC_W  = 3;
    localparam int RUN_W  = 4;
    localparam int MAX_DEPTH = 4;

    localparam int LOCK_POS  = 0;
    localparam int DEPTH_LSB = 4;
    localparam int PRPT_LSB  = 8;
    localparam int ORPT_LSB  = 12;

    typedef struct packed {
        logic [CODE_W-1:0] oth_rpt;
        logic [CODE_W-1:0] pci_rpt;
        logic [CODE_W-1:0] depth;
        logic              core_off;
    } arb_cfg_t;

    function automatic logic [OCC_W-1:0] depth_of(input logic [CODE_W-1:0] code);
        if (code[CODE_W-1])
            return OCC_W'(1);
        return OCC_W'(code) + OCC_W'(1);
    endfunction

    function automatic logic [RUN_W-1:0] limit_of(input logic [CODE_W-1:0] code);
        return RUN_W'(code) + RUN_W'(1);
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(input arb_cfg_t c);
        logic [CFG_W-1:0] w;
        w = '0;
        w[LOCK_POS]                   = c.core_off;
        w[DEPTH_LSB +: CODE_W]        = c.depth;
        w[PRPT_LSB  +: CODE_W]        = c.pci_rpt;
        w[ORPT_LSB  +: CODE_W]        = c.oth_rpt;
        return w;
    endfunction

    function automatic arb_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        arb_cfg_t c;
        c.core_off = w[LOCK_POS];
        c.depth    = w[DEPTH_LSB +: CODE_W];
        c.pci_rpt  = w[PRPT_LSB  +: CODE_W];
        c.oth_rpt  = w[ORPT_LSB  +: CODE_W];
        return c;
    endfunction

endpackage

// File: rtl/sbarb_cfg_reg.sv
module sbarb_cfg_reg
    import sbarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_core_off,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output arb_cfg_t         cfg,
    output logic [CFG_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg          <= '0;
            cfg.core_off <= boot_core_off;
        end else if (wr_en) begin
            cfg <= unpack_cfg(wr_data);
        end
    end

    assign rd_data = pack_cfg(cfg);

    AST_BOOT_LOAD: assert property (@(posedge clk)
        $past(rst) |-> (cfg.core_off == $past(boot_core_off))) else $error("boot load"); // R1

endmodule

// File: rtl/sbarb_credit.sv
module sbarb_credit
    import sbarb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] depth_code,
    input  logic              gnt_any,
    input  logic              done,
    output logic              room
);

    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] busy;
    logic [OCC_W-1:0] lim;
    logic             take;

    assign lim  = depth_of(depth_code);
    assign busy = occ_q + OCC_W'(gnt_any);
    assign room = busy < lim;
    assign take = done && (occ_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            occ_q <= '0;
        else
            occ_q <= busy - OCC_W'(take);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        busy <= OCC_W'(MAX_DEPTH)) else $error("outstanding overflow"); // R6

    AST_GRANT_HAD_ROOM: assert property (@(posedge clk) disable iff (rst)
        gnt_any |-> $past(room)) else $error("grant without room"); // R6

endmodule

// File: rtl/sbarb_rr_pick.sv
module sbarb_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  elig,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] win
);

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= N)
                idx = idx - N;
            if (elig[idx]) begin
                found = 1'b1;
                win   = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/sbus_arbiter.sv
module sbus_arbiter
    import sbarb_pkg::*;
#(
    parameter int NUM_M    = 4,
    parameter int CORE_IDX = 0,
    parameter int PCI_IDX  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boot_core_off,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic [NUM_M-1:0] req,
    input  logic [NUM_M-1:0] rpt_req,
    input  logic             xfer_done,
    output logic [NUM_M-1:0] gnt
);

    localparam int IW = (NUM_M > 1) ? $clog2(NUM_M) : 1;
    localparam logic [IW-1:0] LAST = IW'(NUM_M - 1);

    arb_cfg_t         cfg;
    logic             room;
    logic [NUM_M-1:0] elig;
    logic [NUM_M-1:0] gnt_q, gnt_d;
    logic [IW-1:0]    own_q, own_d, start, pick;
    logic             found, hold, fire;
    logic [RUN_W-1:0] run_q, run_d, own_lim;

    sbarb_cfg_reg u_cfg (
        .clk           (clk),
        .rst           (rst),
        .boot_core_off (boot_core_off),
        .wr_en         (cfg_we),
        .wr_data       (cfg_wdata),
        .cfg           (cfg),
        .rd_data       (cfg_rdata)
    );

    sbarb_credit u_credit (
        .clk        (clk),
        .rst        (rst),
        .depth_code (cfg.depth),
        .gnt_any    (|gnt_q),
        .done       (xfer_done),
        .room       (room)
    );

    always_comb begin
        elig = req;
        if (cfg.core_off)
            elig[CORE_IDX] = 1'b0;
    end

    assign own_lim = (own_q == IW'(PCI_IDX)) ? limit_of(cfg.pci_rpt)
                                             : limit_of(cfg.oth_rpt);
    assign hold    = (run_q != '0) && elig[own_q] && rpt_req[own_q] && (run_q < own_lim);
    assign start   = (own_q == LAST) ? '0 : own_q + IW'(1);

    sbarb_rr_pick #(.N(NUM_M), .IW(IW)) u_pick (
        .elig  (elig),
        .start (start),
        .found (found),
        .win   (pick)
    );

    always_comb begin
        gnt_d = '0;
        own_d = own_q;
        run_d = run_q;
        fire  = 1'b0;
        if (room) begin
            if (hold) begin
                fire  = 1'b1;
                run_d = run_q + RUN_W'(1);
            end else if (found) begin
                fire  = 1'b1;
                own_d = pick;
                run_d = RUN_W'(1);
            end
        end
        if (fire)
            gnt_d[own_d] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= '0;
            own_q <= LAST;
            run_q <= '0;
        end else begin
            gnt_q <= gnt_d;
            own_q <= own_d;
            run_q <= run_d;
        end
    end

    assign gnt = gnt_q;

    AST_CORE_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        gnt_q[CORE_IDX] |-> !$past(cfg.core_off)) else $error("core granted while locked"); // R3

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q)) else $error("grant not one-hot"); // R4

    AST_RUN_CAP: assert property (@(posedge clk) disable iff (rst)
        ((|gnt_q) && (run_q > RUN_W'(1))) |-> (run_q <= $past(own_lim))) else $error("burst limit"); // R8 R9

    for (genvar i = 0; i < NUM_M; i++) begin : g_req_chk
        AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
            gnt_q[i] |-> $past(req[i])) else $error("grant without request"); // R4
    end

endmodule

// File: tb/sbus_arbiter_bench.sv
module sbus_arbiter_bench;

    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          boot_core_off = 1'b1;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NM-1:0] req = '0;
    logic [NM-1:0] rpt_req = '0;
    logic          xfer_done;
    logic [NM-1:0] gnt;

    logic auto_done = 1'b0;
    logic man_done  = 1'b0;
    logic done_dly  = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    always @(posedge clk) done_dly <= |gnt;
    assign xfer_done = auto_done ? done_dly : man_done;

    sbus_arbiter #(.NUM_M(NM), .CORE_IDX(0), .PCI_IDX(1)) u_sbus_arbiter (
        .clk           (clk),
        .rst           (rst),
        .boot_core_off (boot_core_off),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .req           (req),
        .rpt_req       (rpt_req),
        .xfer_done     (xfer_done),
        .gnt           (gnt)
    );

    // {req, rpt_req, expected gnt}; depth 4, PCI limit 3, shared limit 2
    localparam logic [11:0] VEC [21] = '{
        12'b1111_0000_0001, 12'b1111_0000_0010, 12'b1111_0000_0100,
        12'b1111_0000_1000, 12'b1111_0000_0001, 12'b1111_0010_0010,
        12'b1111_0010_0010, 12'b1111_0010_0010, 12'b1111_0010_0100,
        12'b1111_0100_0100, 12'b1111_0100_1000, 12'b0100_0100_0100,
        12'b0100_0100_0100, 12'b0100_0100_0100, 12'b0101_0100_0100,
        12'b0101_0100_0001, 12'b0000_0000_0000, 12'b1010_1000_0010,
        12'b1010_1000_1000, 12'b1010_1000_1000, 12'b1010_1000_0010
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        auto_done = 1'b0;
        req = '0;
        rpt_req = '0;
        man_done = 1'b1;
        repeat (6) tick();
        man_done = 1'b0;
    endtask

    task automatic count_grants(input int cycles, output int n);
        n = 0;
        for (int c = 0; c < cycles; c++) begin
            tick();
            if (|gnt) n++;
        end
    endtask

    task automatic do_reset(input logic boot);
        rst = 1'b1;
        boot_core_off = boot;
        req = '0;
        rpt_req = '0;
        auto_done = 1'b0;
        man_done = 1'b0;
        repeat (3) tick();
        check({28'b0, gnt}, 32'h0, "R1 grant low in reset");
        rst = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        int core_hits;
        tick();
        do_reset(1'b1);
        check(cfg_rdata, 32'h1, "R1 strap loads core lock");
        check({28'b0, gnt}, 32'h0, "R1 no grant after reset");

        // R2 readback, core still locked
        wr_cfg(32'h0000_1231);
        check(cfg_rdata, 32'h0000_1231, "R2 readback");
        auto_done = 1'b1;

        // R3 locked core is never granted
        req = 4'b0001;
        count_grants(5, n);
        check(n, 0, "R3 lone core request ignored while locked");
        req = 4'b1111;
        core_hits = 0;
        n = 0;
        for (int c = 0; c < 12; c++) begin
            tick();
            if (gnt[0]) core_hits++;
            if (|gnt) n++;
        end
        check(core_hits, 0, "R3 core skipped in contention");
        check(n, 12, "R10 others served every cycle");
        req = '0;
        tick();
        wr_cfg(32'h0000_1230);
        req = 4'b0001;
        tick();
        check({28'b0, gnt}, 32'h1, "R3 core granted after unlock");
        req = '0;

        // table walk from a fresh reset
        do_reset(1'b0);
        check(cfg_rdata, 32'h0, "R1 strap low");
        wr_cfg(32'h0000_1230);
        auto_done = 1'b1;
        for (int i = 0; i < 21; i++) begin
            req     = VEC[i][11:8];
            rpt_req = VEC[i][7:4];
            tick();
            check({28'b0, gnt}, {28'b0, VEC[i][3:0]},
                  $sformatf("R7 R8 R9 R4 vector %0d", i));
        end

        // R2 reserved bits read 0
        drain();
        wr_cfg(32'hFFFF_FFFF);
        check(cfg_rdata, 32'h0000_7771, "R2 reserved bits read zero");

        // R5 reserved depth code acts as depth 1
        wr_cfg(32'h0000_0070);
        req = 4'b0010;
        count_grants(10, n);
        check(n, 1, "R5 reserved depth code");
        drain();

        // R5 R6 each legal depth code
        for (int d = 0; d < 4; d++) begin
            wr_cfg(32'(d) << 4);
            req = 4'b0010;
            count_grants(10, n);
            check(n, d + 1, $sformatf("R5 R6 depth code %0d", d));
            drain();
        end

        // R6 completion frees room, grant two cycles later
        wr_cfg(32'h0);
        req = 4'b0010;
        count_grants(6, n);
        check(n, 1, "R6 depth 1 holds one");
        man_done = 1'b1;
        tick();
        man_done = 1'b0;
        check({28'b0, gnt}, 32'h0, "R6 no grant in completion cycle");
        tick();
        check({28'b0, gnt}, 32'h2, "R6 grant after completion");
        drain();

        // R8 R9 R10 sustained contention with hold flags
        wr_cfg(32'h0000_1230);
        auto_done = 1'b1;
        begin
            int seen [NM];
            int maxr [NM];
            int last;
            int run;
            for (int m = 0; m < NM; m++) begin
                seen[m] = 0;
                maxr[m] = 0;
            end
            last = -1;
            run = 0;
            req = 4'b1111;
            rpt_req = 4'b1111;
            for (int c = 0; c < 60; c++) begin
                tick();
                for (int m = 0; m < NM; m++) begin
                    if (gnt[m]) begin
                        run = (m == last) ? run + 1 : 1;
                        last = m;
                        seen[m]++;
                        if (run > maxr[m]) maxr[m] = run;
                    end
                end
            end
            req = '0;
            rpt_req = '0;
            for (int m = 0; m < NM; m++)
                check(seen[m] > 0, 1, $sformatf("R10 master %0d served", m));
            check(maxr[1], 3, "R8 PCI burst limit");
            check(maxr[0], 2, "R9 core burst limit");
            check(maxr[2], 2, "R9 master 2 burst limit");
            check(maxr[3], 2, "R9 master 3 burst limit");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule